// File: doc/BRIEF.md
# Match-Driven Debug Trigger Sequencer

This block is the state sequencer of an on-chip debug unit. Once armed it sits in stage one. It then moves between stage one, stage two and stage three, and finally to a terminal "final" condition. Each move is driven by single-cycle match pulses from three comparator channels. Each stage has its own 4-bit transition code. The code says which match channel moves the sequencer out of that stage, and where it goes. Some codes route different channels to different destinations. When the final condition is reached, a sticky flag is raised and the sequencer disarms itself.

The three stage codes and a read-only flag register all share a single bus address. A 2-bit bank-select input picks which of the four is seen at that address. Writes to the codes are refused while the sequencer is armed, so a running trigger cannot be reprogrammed under its own feet. The block has no data stream: matches, arm, disarm and the register bus are plain control pins, and no back-pressure applies.

Top module: `dts_seq`

## Requirements
- R1: After reset all three stage codes are 0, `state_o` is 00, `armed_o` is 0, `final_o` is 0, and every bank reads 0x00.
- R2: When `reg_addr_i` equals the parameter `SEQ_ADDR`, `reg_rdata_o` shows the bank chosen by `bank_sel_i`, combinationally. Bank 00 is the stage-one code, bank 01 the stage-two code and bank 10 the stage-three code, each in bits 3:0 with bits 7:4 zero. Bank 11 is the flag register: bit 3 is the final flag, bits 2:0 are the one-hot channel that caused final entry, and bits 7:4 are zero. Any other address reads 0x00.
- R3: A write (`reg_wr_i` high at `SEQ_ADDR`) stores `reg_wdata_i[3:0]` into the selected code at the next clock edge, but only while `armed_o` is 0. Writes while armed, and writes to bank 11, leave every register unchanged.
- R4: `state_o` encodes 00 idle, 01 stage one, 10 stage two and 11 stage three. An `arm_i` pulse enters stage one, sets `armed_o` and clears the final flag and its cause. A `disarm_i` pulse returns to idle with `armed_o` 0, and takes precedence over `arm_i` in the same cycle. Matches have no effect while not armed.
- R5: Code table. Channels are written as ch0, ch1, ch2; S2 and S3 are stage two and stage three, F is final. 0000: any channel goes to F. 0001: ch1 goes to S3. 0010: ch2 goes to S2. 0011: ch1 goes to S2. 0100: ch0 goes to S2 and ch1 goes to S3. 0101: ch0 goes to F and ch1 goes to S3. 0110: ch0 goes to S2 and ch2 goes to S3. 0111: ch0 or ch1 goes to S2. 1001: ch0 goes to S3.
- R6: Codes 1000 and 1010 to 1111 never cause a transition. A channel that the active code does not name has no effect on the state.
- R7: A channel takes part only in a cycle where both `match_i[n]` and `match_en_i[n]` are high.
- R8: If several named, enabled channels pulse in the same cycle, the lowest-numbered one decides the transition.
- R9: Stage two and stage three use the same code table, read from their own code registers. When the deciding channel's target is the current stage, the state holds.
- R10: On a transition to F, `state_o` becomes 00, `armed_o` becomes 0, `final_o` becomes 1 and stays 1 until the next arm, and the flag register records the deciding channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm pulse: enter stage one |
| disarm_i | input | 1 | Disarm pulse: return to idle |
| match_i | input | 3 | Single-cycle match pulses, one per channel |
| match_en_i | input | 3 | Per-channel comparator enable |
| bank_sel_i | input | 2 | Bank select for the shared address |
| reg_addr_i | input | ADDR_W | Register bus address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| armed_o | output | 1 | Sequencer armed |
| state_o | output | 2 | Current stage, encoded as in R4 |
| final_o | output | 1 | Sticky final-condition flag |

## Verification
The bench starts from each of the three stages and applies every code with every combination of match pulses and enables. This covers the split codes, same-cycle collisions and self-targeting codes. A design with a reversed priority, or one that ignored the enables, would land in the wrong stage for a multi-pulse pattern. A design that treated a self-target as a real move, or let reserved codes fall through to the "any match" behaviour, would leave the stage it should hold. Separate directed cases write while armed, write the flag bank and write the upper nibble; a broken lock would show up as a changed code on read-back. Further cases send matches while idle and give arm and disarm in the same cycle; a wrong precedence would leave the sequencer armed.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int NCH    = 3;
  localparam int CODE_W = 4;
  localparam int DATA_W = 8;
  localparam int NSTAGE = 3;

  // stage encoding on state_o
  localparam logic [1:0] ST_IDLE  = 2'b00;
  localparam logic [1:0] ST_ONE   = 2'b01;
  localparam logic [1:0] ST_TWO   = 2'b10;
  localparam logic [1:0] ST_THREE = 2'b11;

  // destination of one channel under one code
  localparam logic [1:0] TG_NONE  = 2'd0;
  localparam logic [1:0] TG_TWO   = 2'd1;
  localparam logic [1:0] TG_THREE = 2'd2;
  localparam logic [1:0] TG_FINAL = 2'd3;

  function automatic logic [1:0] code_target(input logic [CODE_W-1:0] code, input int ch);
    logic [1:0] t;
    t = TG_NONE;
    case (code)
      4'b0000: t = TG_FINAL;
      4'b0001: if (ch == 1) t = TG_THREE;
      4'b0010: if (ch == 2) t = TG_TWO;
      4'b0011: if (ch == 1) t = TG_TWO;
      4'b0100: if (ch == 0) t = TG_TWO;   else if (ch == 1) t = TG_THREE;
      4'b0101: if (ch == 0) t = TG_FINAL; else if (ch == 1) t = TG_THREE;
      4'b0110: if (ch == 0) t = TG_TWO;   else if (ch == 2) t = TG_THREE;
      4'b0111: if (ch <= 1) t = TG_TWO;
      4'b1001: if (ch == 0) t = TG_THREE;
      default: t = TG_NONE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/dts_route.sv
module dts_route
  import dts_pkg::*;
#(
  parameter int SELF = 1  // 1, 2 or 3: the stage this decoder serves
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NCH-1:0]    hits,
  output logic              go,
  output logic [1:0]        tgt,
  output logic [NCH-1:0]    win
);
  logic [1:0]     tg [NCH];
  logic [NCH-1:0] cand;
  logic [NCH-1:0] cand_neg;
  logic           self_hit;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign tg[ch]   = code_target(code, ch);
    assign cand[ch] = hits[ch] && (tg[ch] != TG_NONE);
  end

  // lowest-numbered candidate wins
  assign cand_neg = ~cand + {{(NCH-1){1'b0}}, 1'b1};
  assign win      = cand & cand_neg;

  always_comb begin
    tgt = TG_NONE;
    for (int ch = 0; ch < NCH; ch++)
      if (win[ch]) tgt = tg[ch];
  end

  assign self_hit = ((SELF == 2) && (tgt == TG_TWO)) ||
                    ((SELF == 3) && (tgt == TG_THREE));
  assign go       = (|win) && !self_hit;
endmodule

// File: rtl/dts_regbank.sv
module dts_regbank
  import dts_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SEQ_ADDR = 8'h3A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     armed,
  input  logic [1:0]               bank,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     final_flag,
  input  logic [NCH-1:0]           cause,
  output logic [NSTAGE*CODE_W-1:0] ctrl_flat,
  output logic [DATA_W-1:0]        rdata
);
  localparam int PAD = DATA_W - CODE_W;

  logic [CODE_W-1:0] ctrl_q [NSTAGE];
  logic              hit;
  logic              wr_ok;

  assign hit   = (addr == SEQ_ADDR);
  assign wr_ok = wr && hit && !armed && (bank != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSTAGE; k++) ctrl_q[k] <= '0;
    end else if (wr_ok) begin
      for (int k = 0; k < NSTAGE; k++)
        if (bank == 2'(k)) ctrl_q[k] <= wdata[CODE_W-1:0];
    end
  end

  for (genvar k = 0; k < NSTAGE; k++) begin : g_flat
    assign ctrl_flat[k*CODE_W +: CODE_W] = ctrl_q[k];
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (bank)
        2'b00:   rdata = {{PAD{1'b0}}, ctrl_q[0]};
        2'b01:   rdata = {{PAD{1'b0}}, ctrl_q[1]};
        2'b10:   rdata = {{PAD{1'b0}}, ctrl_q[2]};
        default: rdata = {{(DATA_W-NCH-1){1'b0}}, final_flag, cause};
      endcase
    end
  end
endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
  import dts_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           disarm,
  input  logic           go,
  input  logic [1:0]     tgt,
  input  logic [NCH-1:0] win,
  output logic [1:0]     state,
  output logic           armed,
  output logic           final_flag,
  output logic [NCH-1:0] cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      final_flag <= 1'b0;
      cause      <= '0;
    end else if (disarm) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else if (arm) begin
      state      <= ST_ONE;
      armed      <= 1'b1;
      final_flag <= 1'b0;
      cause      <= '0;
    end else if (armed && go) begin
      case (tgt)
        TG_TWO:   state <= ST_TWO;
        TG_THREE: state <= ST_THREE;
        TG_FINAL: begin
          state      <= ST_IDLE;
          armed      <= 1'b0;
          final_flag <= 1'b1;
          cause      <= win;
        end
        default:  state <= state;
      endcase
    end
  end
endmodule

// File: rtl/dts_seq.sv
module dts_seq
  import dts_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SEQ_ADDR = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic [2:0]        match_i,
  input  logic [2:0]        match_en_i,
  input  logic [1:0]        bank_sel_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              armed_o,
  output logic [1:0]        state_o,
  output logic              final_o
);
  logic [NSTAGE*CODE_W-1:0] ctrl_flat;
  logic [NCH-1:0]           hits;
  logic [NCH-1:0]           cause;
  logic                     r_go  [NSTAGE];
  logic [1:0]               r_tgt [NSTAGE];
  logic [NCH-1:0]           r_win [NSTAGE];
  logic                     sel_go;
  logic [1:0]               sel_tgt;
  logic [NCH-1:0]           sel_win;

  assign hits = match_i & match_en_i;

  dts_regbank #(.ADDR_W(ADDR_W), .SEQ_ADDR(SEQ_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .armed(armed_o), .bank(bank_sel_i),
    .addr(reg_addr_i), .wr(reg_wr_i), .wdata(reg_wdata_i),
    .final_flag(final_o), .cause(cause), .ctrl_flat(ctrl_flat),
    .rdata(reg_rdata_o)
  );

  for (genvar k = 0; k < NSTAGE; k++) begin : g_route
    dts_route #(.SELF(k + 1)) u_route (
      .code(ctrl_flat[k*CODE_W +: CODE_W]), .hits(hits),
      .go(r_go[k]), .tgt(r_tgt[k]), .win(r_win[k])
    );
  end

  always_comb begin
    sel_go  = 1'b0;
    sel_tgt = TG_NONE;
    sel_win = '0;
    for (int k = 0; k < NSTAGE; k++)
      if (state_o == 2'(k + 1)) begin
        sel_go  = r_go[k];
        sel_tgt = r_tgt[k];
        sel_win = r_win[k];
      end
  end

  dts_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm_i), .disarm(disarm_i),
    .go(sel_go), .tgt(sel_tgt), .win(sel_win),
    .state(state_o), .armed(armed_o), .final_flag(final_o), .cause(cause)
  );
endmodule

// File: rtl/dts_seq_chk.sv
module dts_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        arm_i,
  input logic        disarm_i,
  input logic [2:0]  match_i,
  input logic [2:0]  match_en_i,
  input logic [1:0]  bank_sel_i,
  input logic [7:0]  reg_rdata_o,
  input logic        armed_o,
  input logic [1:0]  state_o,
  input logic        final_o,
  input logic [11:0] ctrl_flat,
  input logic [2:0]  cause
);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel_i != 2'b11) |-> (reg_rdata_o[7:4] == 4'h0));

  assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> $stable(ctrl_flat));

  assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !disarm_i) |=> (armed_o && state_o == 2'b01 && !final_o));

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> (!armed_o && state_o == 2'b00));

  assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |-> (state_o == 2'b00));

  assert_no_hit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && (match_i & match_en_i) == 3'b000 && !arm_i && !disarm_i)
      |=> (armed_o && $stable(state_o)));

  assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    final_o |-> ($countones(cause) == 1));

  assert_final_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(final_o) |-> (!armed_o && state_o == 2'b00 && $past(armed_o)));
endmodule

bind dts_seq dts_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
  .match_i(match_i), .match_en_i(match_en_i), .bank_sel_i(bank_sel_i),
  .reg_rdata_o(reg_rdata_o), .armed_o(armed_o), .state_o(state_o),
  .final_o(final_o), .ctrl_flat(ctrl_flat), .cause(cause)
);

// File: tb/dts_seq_bench.sv
`timescale 1ns/1ps
module dts_seq_bench;
  localparam logic [7:0] ADR = 8'h3A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_i = 1'b0, disarm_i = 1'b0, reg_wr_i = 1'b0;
  logic [2:0] match_i = '0, match_en_i = '0;
  logic [1:0] bank_sel_i = '0;
  logic [7:0] reg_addr_i = ADR, reg_wdata_i = '0, reg_rdata_o;
  logic       armed_o, final_o;
  logic [1:0] state_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dts_seq #(.ADDR_W(8), .SEQ_ADDR(ADR)) u_dts_seq (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
    .match_i(match_i), .match_en_i(match_en_i), .bank_sel_i(bank_sel_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .armed_o(armed_o), .state_o(state_o),
    .final_o(final_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] b, logic [7:0] d);
    reg_addr_i = ADR; bank_sel_i = b; reg_wdata_i = d; reg_wr_i = 1'b1;
    cyc();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] b, output logic [7:0] v);
    reg_addr_i = ADR; bank_sel_i = b;
    #0.5 v = reg_rdata_o;
  endtask

  task automatic pulse(logic a, logic d);
    arm_i = a; disarm_i = d;
    cyc();
    arm_i = 1'b0; disarm_i = 1'b0;
  endtask

  task automatic hit(logic [2:0] m, logic [2:0] e);
    match_i = m; match_en_i = e;
    cyc();
    match_i = '0; match_en_i = '0;
  endtask

  // destination per requirement R5: 0 none, 2 stage two, 3 stage three, 4 final
  function automatic int dest(int code, int ch);
    case (code)
      0: return 4;
      1: return (ch == 1) ? 3 : 0;
      2: return (ch == 2) ? 2 : 0;
      3: return (ch == 1) ? 2 : 0;
      4: return (ch == 0) ? 2 : (ch == 1) ? 3 : 0;
      5: return (ch == 0) ? 4 : (ch == 1) ? 3 : 0;
      6: return (ch == 0) ? 2 : (ch == 2) ? 3 : 0;
      7: return (ch <= 1) ? 2 : 0;
      9: return (ch == 0) ? 3 : 0;
      default: return 0; // R6 reserved / unused codes
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    check("R1 state", state_o, 0);
    check("R1 armed", armed_o, 0);
    check("R1 final", final_o, 0);
    for (int b = 0; b < 4; b++) begin
      rd(2'(b), v); check("R1 bank read", v, 0);
    end

    // R3 only low nibble stored; R2 decode
    wr(2'b00, 8'hFF); rd(2'b00, v); check("R3 low nibble bank0", v, 8'h0F);
    wr(2'b01, 8'hA5); rd(2'b01, v); check("R2 bank1 read", v, 8'h05);
    wr(2'b10, 8'h3C); rd(2'b10, v); check("R2 bank2 read", v, 8'h0C);
    rd(2'b00, v); check("R2 bank0 unaffected", v, 8'h0F);
    wr(2'b11, 8'hFF); rd(2'b11, v); check("R3 flag bank write ignored", v, 0);
    reg_addr_i = 8'h3B; #0.5 check("R2 other address", reg_rdata_o, 0);
    reg_addr_i = ADR;

    // R4 idle ignores matches (bank0 code 1111 -> set 0000 first)
    wr(2'b00, 8'h00);
    hit(3'b111, 3'b111);
    check("R4 idle match state", state_o, 0);
    check("R4 idle match final", final_o, 0);

    // R3 write lock while armed
    pulse(1, 0);
    check("R4 arm state", state_o, 1);
    wr(2'b00, 8'h07); wr(2'b01, 8'h09);
    pulse(0, 1);
    rd(2'b00, v); check("R3 lock bank0", v, 8'h00);
    rd(2'b01, v); check("R3 lock bank1", v, 8'h05);
    check("R4 disarm state", state_o, 0);

    // R4 disarm wins over arm
    pulse(1, 1);
    check("R4 arm+disarm armed", armed_o, 0);
    check("R4 arm+disarm state", state_o, 0);

    // R4 re-arm from stage two returns to stage one
    wr(2'b00, 8'h03); pulse(1, 0); hit(3'b010, 3'b111);
    check("R4 reach stage two", state_o, 2);
    pulse(1, 0);
    check("R4 re-arm stage one", state_o, 1);
    pulse(0, 1);

    // R5..R10 sweep
    for (int s = 1; s <= 3; s++)
      for (int code = 0; code < 16; code++)
        for (int pat = 0; pat < 64; pat++) begin
          int exp_st, exp_fin, exp_cause, d;
          logic [2:0] m, e;
          m = pat[2:0]; e = pat[5:3];
          pulse(0, 1);
          wr(2'b00, 8'((s == 1) ? code : (s == 2) ? 3 : 1));
          if (s > 1) wr(2'(s - 1), 8'(code));
          pulse(1, 0);
          if (s > 1) begin
            hit(3'b010, 3'b111);
            check("R9 reach stage", state_o, s);
          end
          hit(m, e);
          exp_st = s; exp_fin = 0; exp_cause = 0;
          for (int ch = 0; ch < 3; ch++) begin
            d = dest(code, ch);
            if (m[ch] && e[ch] && d != 0 && exp_cause == 0) begin
              exp_cause = 1 << ch;
              if (d == 4) begin exp_st = 0; exp_fin = 1; end
              else if (d != s) exp_st = d; // R9 self target holds
            end
          end
          check("R5 R6 R7 R8 R9 state", state_o, exp_st);
          check("R10 final flag", final_o, exp_fin);
          check("R10 armed", armed_o, exp_fin ? 0 : 1);
          if (exp_fin) begin
            rd(2'b11, v);
            check("R10 R8 flag register", v, 8'h08 | exp_cause);
          end
        end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule